// File: doc/BRIEF.md
# Video Memory Block Copy Engine

This block copies a block of bytes from anywhere in the system address space into the 8 KiB video memory window at 0x8000–0x9FFF. Software programs it through five byte-wide registers: a source address, a destination address and a control byte. Both addresses are kept 16-byte aligned. The control byte holds the block length as a count of 16-byte units minus one and a pacing-mode bit. Writing the control byte starts the copy.

The engine drives a simple byte-wide memory master: a read strobe with an address, where the data returns on the following cycle, and a write strobe with an address and data. In free-running mode the copy runs back to back at one byte every two cycles. In blank-paced mode it moves one 16-byte unit on each rising edge of the horizontal-blank input and then waits. While the copy is in progress, software can read the control register to get the busy flag and the number of units still to go.

Top module: `vramDmaTop`

## Requirements
- R1: Register decode is 0xFF51 source high byte, 0xFF52 source low byte, 0xFF53 destination high byte, 0xFF54 destination low byte, 0xFF55 control. A write to any other address has no effect, and in particular it does not start a copy.
- R2: Bits 3:0 of a value written to the source low or destination low register are stored as zero, so every block starts on a 16-byte boundary.
- R3: The block length in bytes is (control bits 6:0 + 1) × 16, covering 16 to 2048 bytes, and the engine issues exactly that many memory writes.
- R4: When control bit 7 is 0, the copy runs back to back. Each byte takes one read cycle followed by one write cycle. The busy flag drops exactly 2 × length cycles after the clock edge that takes the control write.
- R5: When control bit 7 is 1, no byte moves until a rising edge of the blank input. Each rising edge moves exactly 16 bytes. Holding blank high past the end of a unit moves nothing more.
- R6: Reading 0xFF55 returns the busy flag in bit 7 and floor(remaining bytes / 16) − 1 (modulo 128) in bits 6:0. When idle after reset or after a completed copy it reads 0x7F. Reading any other address returns 0xFF.
- R7: Write addresses are 0x8000 | ((destination[12:0] + i) mod 8192) for byte i. Destination bits 15:13 are ignored.
- R8: Byte i is read from (source + i) mod 65536, and that byte is written unchanged to destination byte i.
- R9: A control write while a paced copy waits for blank restarts the engine with the new length and mode. The restart continues from the source and destination addresses reached so far.
- R10: After reset the engine is idle and both memory strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 16 | CPU register address |
| regWrEn | input | 1 | CPU register write strobe |
| regWrData | input | 8 | CPU register write data |
| regRdData | output | 8 | CPU register read data (combinational from regAddr) |
| hblank | input | 1 | Horizontal-blank level; rising edges pace the blank mode |
| memRdEn | output | 1 | Source read strobe |
| memRdAddr | output | 16 | Source read address |
| memRdData | input | 8 | Source data, valid the cycle after memRdEn |
| memWrEn | output | 1 | Video memory write strobe |
| memWrAddr | output | 16 | Video memory write address |
| memWrData | output | 8 | Video memory write data |

## Verification
The hardest state to reach from the ports is a paced copy parked between units. There, the blank level is still high from the previous edge, part of the count has been used and both address registers have moved on. The bench holds blank high far longer than a unit lasts, then pulses it briefly. It checks the write count and the readback after each step. It then issues a free-running control write from that parked state and confirms that the next 16 bytes land exactly where the paced copy stopped. Free-running copies are swept over many lengths, including the full 2048 bytes and both address wraps, and every destination byte is checked against the arithmetic source pattern.

// File: rtl/vdmaPkg.sv
package vdmaPkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_READ  = 2'd2,
    ST_WRITE = 2'd3
  } dmaStateT;

  typedef struct packed {
    logic loadLen;
    logic stepByte;
  } dmaStrobeT;

  localparam int OFF_SRC_HI = 0;
  localparam int OFF_SRC_LO = 1;
  localparam int OFF_DST_HI = 2;
  localparam int OFF_DST_LO = 3;
  localparam int OFF_CTL    = 4;

endpackage

// File: rtl/vdmaDatapath.sv
module vdmaDatapath
  import vdmaPkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int UNIT_LOG2  = 4,
  parameter int LEN_W      = 7,
  parameter int WIN_W      = 13,
  parameter logic [15:0] WIN_BASE = 16'h8000,
  parameter logic [15:0] REG_BASE = 16'hFF51
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  dmaStrobeT         strobe,
  input  logic              active,
  output logic              ctlWrite,
  output logic              ctlMode,
  output logic              lastByte,
  output logic              unitEnd,
  output logic              remZero,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [ADDR_W-1:0] dstAddr,
  input  logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] wrData
);

  localparam int CNT_W = LEN_W + UNIT_LOG2 + 1;

  logic [ADDR_W-1:0] srcQ;
  logic [WIN_W-1:0]  dstQ;
  logic [CNT_W-1:0]  remQ;
  logic [CNT_W-1:0]  loadCount;
  logic [DATA_W-1:0] alignedByte;
  logic [LEN_W-1:0]  unitsCode;
  logic hitSrcHi, hitSrcLo, hitDstHi, hitDstLo, hitCtl;

  // register decode
  always_comb begin
    hitSrcHi = (regAddr == REG_BASE + ADDR_W'(OFF_SRC_HI));
    hitSrcLo = (regAddr == REG_BASE + ADDR_W'(OFF_SRC_LO));
    hitDstHi = (regAddr == REG_BASE + ADDR_W'(OFF_DST_HI));
    hitDstLo = (regAddr == REG_BASE + ADDR_W'(OFF_DST_LO));
    hitCtl   = (regAddr == REG_BASE + ADDR_W'(OFF_CTL));
  end

  assign ctlWrite    = regWrEn && hitCtl;
  assign ctlMode     = regWrData[LEN_W];
  assign alignedByte = {regWrData[DATA_W-1:UNIT_LOG2], UNIT_LOG2'(0)};
  assign loadCount   = (CNT_W'(regWrData[LEN_W-1:0]) + CNT_W'(1)) << UNIT_LOG2;

  // source address: byte writes, else advance per moved byte
  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcQ <= '0;
    end else if (regWrEn && hitSrcHi) begin
      srcQ[ADDR_W-1:DATA_W] <= regWrData;
    end else if (regWrEn && hitSrcLo) begin
      srcQ[DATA_W-1:0] <= alignedByte;
    end else if (strobe.stepByte) begin
      srcQ <= srcQ + ADDR_W'(1);
    end
  end

  // destination offset inside the video window
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dstQ <= '0;
    end else if (regWrEn && hitDstHi) begin
      dstQ[WIN_W-1:DATA_W] <= regWrData[WIN_W-DATA_W-1:0];
    end else if (regWrEn && hitDstLo) begin
      dstQ[DATA_W-1:0] <= alignedByte;
    end else if (strobe.stepByte) begin
      dstQ <= dstQ + WIN_W'(1);
    end
  end

  // remaining byte count
  always_ff @(posedge clk) begin
    if (!rstN) begin
      remQ <= '0;
    end else if (strobe.loadLen) begin
      remQ <= loadCount;
    end else if (strobe.stepByte && !remZero) begin
      remQ <= remQ - CNT_W'(1);
    end
  end

  assign remZero  = (remQ == '0);
  assign lastByte = (remQ == CNT_W'(1));
  assign unitEnd  = (remQ[UNIT_LOG2-1:0] == UNIT_LOG2'(1));

  assign unitsCode = LEN_W'(remQ >> UNIT_LOG2) - LEN_W'(1);
  assign regRdData = hitCtl ? {active, unitsCode} : '1;

  assign srcAddr = srcQ;
  assign dstAddr = WIN_BASE | ADDR_W'(dstQ);
  assign wrData  = rdData;

  p_count_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stepByte && !strobe.loadLen && !remZero) |=> (remQ == $past(remQ) - CNT_W'(1)));

  p_load_whole_units_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadLen |=> (remQ[UNIT_LOG2-1:0] == '0 && remQ != '0));

endmodule

// File: rtl/vdmaControl.sv
module vdmaControl
  import vdmaPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      ctlWrite,
  input  logic      ctlMode,
  input  logic      hblank,
  input  logic      lastByte,
  input  logic      unitEnd,
  input  logic      remZero,
  output dmaStrobeT strobe,
  output logic      active,
  output logic      memRdEn,
  output logic      memWrEn
);

  dmaStateT stateQ, stateD;
  logic pacedQ;
  logic hbPrevQ;
  logic hbRise;

  assign hbRise = hblank && !hbPrevQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hbPrevQ <= 1'b0;
    end else begin
      hbPrevQ <= hblank;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pacedQ <= 1'b0;
    end else if (ctlWrite) begin
      pacedQ <= ctlMode;
    end
  end

  always_comb begin
    stateD = stateQ;
    if (ctlWrite) begin
      stateD = ctlMode ? ST_WAIT : ST_READ;
    end else begin
      case (stateQ)
        ST_IDLE:  stateD = ST_IDLE;
        ST_WAIT:  stateD = hbRise ? ST_READ : ST_WAIT;
        ST_READ:  stateD = ST_WRITE;
        ST_WRITE: begin
          if (lastByte)                stateD = ST_IDLE;
          else if (pacedQ && unitEnd)  stateD = ST_WAIT;
          else                         stateD = ST_READ;
        end
        default:  stateD = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
    end else begin
      stateQ <= stateD;
    end
  end

  assign active          = (stateQ != ST_IDLE);
  assign memRdEn         = (stateQ == ST_READ);
  assign memWrEn         = (stateQ == ST_WRITE);
  assign strobe.loadLen  = ctlWrite;
  assign strobe.stepByte = (stateQ == ST_WRITE) && !ctlWrite;

  p_write_after_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> $past(memRdEn));

  p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(memRdEn && memWrEn));

  p_wait_for_edge_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_WAIT && !hbRise && !ctlWrite) |=> (stateQ == ST_WAIT && !memRdEn));

  p_idle_drained_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(active) |-> remZero);

endmodule

// File: rtl/vramDmaTop.sv
module vramDmaTop
  import vdmaPkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int UNIT_LOG2 = 4,
  parameter int LEN_W     = 7,
  parameter int WIN_W     = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              hblank,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic [DATA_W-1:0] memRdData,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData
);

  dmaStrobeT strobe;
  logic active, ctlWrite, ctlMode, lastByte, unitEnd, remZero;

  vdmaDatapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .UNIT_LOG2(UNIT_LOG2),
    .LEN_W(LEN_W), .WIN_W(WIN_W)
  ) uPath (
    .clk(clk), .rstN(rstN),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData),
    .strobe(strobe), .active(active),
    .ctlWrite(ctlWrite), .ctlMode(ctlMode),
    .lastByte(lastByte), .unitEnd(unitEnd), .remZero(remZero),
    .srcAddr(memRdAddr), .dstAddr(memWrAddr),
    .rdData(memRdData), .wrData(memWrData)
  );

  vdmaControl uCtl (
    .clk(clk), .rstN(rstN),
    .ctlWrite(ctlWrite), .ctlMode(ctlMode), .hblank(hblank),
    .lastByte(lastByte), .unitEnd(unitEnd), .remZero(remZero),
    .strobe(strobe), .active(active),
    .memRdEn(memRdEn), .memWrEn(memWrEn)
  );

endmodule

// File: tb/tb_vramDmaTop.sv
module tb_vramDmaTop;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] regAddr = 16'h0000;
  logic        regWrEn = 1'b0;
  logic [7:0]  regWrData = 8'h00;
  logic [7:0]  regRdData;
  logic        hblank = 1'b0;
  logic        memRdEn, memWrEn;
  logic [15:0] memRdAddr, memWrAddr;
  logic [7:0]  memRdData = 8'h00;
  logic [7:0]  memWrData;

  int total = 0;
  int bad = 0;
  int wrCount = 0;
  int wrOutside = 0;
  logic clrReq = 1'b0;
  logic [7:0] vram [0:8191];

  always #2 clk = ~clk;

  vramDmaTop dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .hblank(hblank),
    .memRdEn(memRdEn), .memRdAddr(memRdAddr), .memRdData(memRdData),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData)
  );

  function automatic logic [7:0] srcByte(input logic [15:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ 8'hA5;
  endfunction

  always @(posedge clk) begin
    if (memRdEn) memRdData <= srcByte(memRdAddr);
  end

  always @(posedge clk) begin
    if (clrReq) begin
      for (int i = 0; i < 8192; i++) vram[i] = 8'hEE;
      wrCount = 0;
      wrOutside = 0;
    end else if (memWrEn) begin
      if (memWrAddr[15:13] != 3'b100) wrOutside = wrOutside + 1;
      vram[memWrAddr[12:0]] = memWrData;
      wrCount = wrCount + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic clearMem();
    @(negedge clk); clrReq = 1'b1;
    @(negedge clk); clrReq = 1'b0;
  endtask

  task automatic regWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic setAddrs(input logic [15:0] src, input logic [15:0] dst);
    regWrite(16'hFF51, src[15:8]);
    regWrite(16'hFF52, src[7:0]);
    regWrite(16'hFF53, dst[15:8]);
    regWrite(16'hFF54, dst[7:0]);
  endtask

  // compares n bytes starting at byte offset 'first' of the block
  task automatic checkBytes(input logic [15:0] src, input logic [15:0] dst,
                            input int first, input int n, input string tag);
    int errs = 0;
    int firstBad = -1;
    logic [15:0] s0 = {src[15:4], 4'h0};
    logic [12:0] d0 = {dst[12:4], 4'h0};
    for (int i = first; i < first + n; i++) begin
      logic [12:0] di = d0 + 13'(i);
      if (vram[di] !== srcByte(s0 + 16'(i))) begin
        errs++;
        if (firstBad < 0) firstBad = i;
      end
    end
    check(errs == 0, tag, errs, 0);
  endtask

  task automatic runGeneral(input logic [15:0] src, input logic [15:0] dst, input logic [6:0] code);
    int n = (int'(code) + 1) * 16;
    int cyc = 0;
    logic [7:0] rd;
    clearMem();
    setAddrs(src, dst);
    regWrite(16'hFF55, {1'b0, code});
    regAddr = 16'hFF55;
    while (cyc < 5000) begin
      @(posedge clk); cyc++;
      @(negedge clk);
      if (!regRdData[7]) break;
    end
    check(cyc == 2 * n, "R4 busy duration", cyc, 2 * n);
    check(wrCount == n, "R3 write count", wrCount, n);
    regRead(16'hFF55, rd);
    check(rd == 8'h7F, "R6 idle readback", rd, 8'h7F);
    checkBytes(src, dst, 0, n, "R2 R7 R8 block contents");
    check(wrOutside == 0, "R7 window", wrOutside, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    check(memRdEn == 1'b0 && memWrEn == 1'b0, "R10 strobes in reset", {memRdEn, memWrEn}, 0);
    rstN = 1'b1;
    regRead(16'hFF55, rd);
    check(rd == 8'h7F, "R10 R6 readback after reset", rd, 8'h7F);
    regRead(16'hFF51, rd);
    check(rd == 8'hFF, "R6 other address reads", rd, 8'hFF);

    // R1: neighbouring addresses do nothing
    clearMem();
    regWrite(16'hFF56, 8'h03);
    regWrite(16'hFF50, 8'h83);
    repeat (20) @(posedge clk);
    regRead(16'hFF55, rd);
    check(rd == 8'h7F && wrCount == 0, "R1 stray write ignored", {rd, 8'(wrCount)}, 16'h7F00);

    // free-running sweep over lengths and address corners
    runGeneral(16'h1230, 16'h8000, 7'd0);
    runGeneral(16'h4567, 16'h012F, 7'd1);   // R2 low nibbles dropped
    runGeneral(16'hFFF0, 16'h0800, 7'd1);   // R8 source wraps
    runGeneral(16'h2000, 16'hFFF0, 7'd2);   // R7 window wraps, high bits ignored
    runGeneral(16'hC0DE, 16'h1A55, 7'd3);
    runGeneral(16'h0000, 16'h0300, 7'd15);
    runGeneral(16'h7A10, 16'h0000, 7'd127); // R3 longest block

    // R6: readback during a free-running copy
    clearMem();
    setAddrs(16'h3000, 16'h0100);
    regWrite(16'hFF55, 8'h03);
    regAddr = 16'hFF55;
    repeat (40) @(posedge clk);
    @(negedge clk);
    check(regRdData == 8'h81, "R6 mid-copy readback", regRdData, 8'h81);
    repeat (120) @(posedge clk);

    // R5: paced copy
    clearMem();
    setAddrs(16'h4123, 16'h0450);
    regWrite(16'hFF55, 8'h83);
    repeat (20) @(posedge clk);
    regRead(16'hFF55, rd);
    check(wrCount == 0, "R5 no move before blank edge", wrCount, 0);
    check(rd == 8'h83, "R6 paced readback before edge", rd, 8'h83);
    @(negedge clk); hblank = 1'b1;
    repeat (100) @(posedge clk);
    regRead(16'hFF55, rd);
    check(wrCount == 16, "R5 one unit per edge, level held", wrCount, 16);
    check(rd == 8'h82, "R6 paced readback after unit", rd, 8'h82);
    @(negedge clk); hblank = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk); hblank = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); hblank = 1'b0;
    repeat (40) @(posedge clk);
    regRead(16'hFF55, rd);
    check(wrCount == 32, "R5 second edge", wrCount, 32);
    check(rd == 8'h81, "R6 paced readback after two units", rd, 8'h81);
    checkBytes(16'h4123, 16'h0450, 0, 32, "R5 R8 paced contents");

    // R9: restart while waiting, free-running, one unit
    regWrite(16'hFF55, 8'h00);
    repeat (40) @(posedge clk);
    regRead(16'hFF55, rd);
    check(wrCount == 48, "R9 restart write count", wrCount, 48);
    check(rd == 8'h7F, "R9 restart completes", rd, 8'h7F);
    checkBytes(16'h4123, 16'h0450, 32, 16, "R9 restart continues addresses");
    check(vram[13'h0450 + 13'd48] == 8'hEE, "R9 nothing past restart block",
          vram[13'h0450 + 13'd48], 8'hEE);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule